// File: doc/BRIEF.md
# Root Hub Status Register

This block is the 32-bit status and control word that a USB host controller keeps for its root hub. Software reaches it through a simple synchronous register port: a select, a write enable, write data and combinational read data. Each bit position means one thing when read and another when written. Some written ones set a flag, some clear a flag, and one issues a command strobe. Reserved positions read as zero and ignore what is written to them.

Inside, the block tracks an over-current indicator through a synchronizer and latches every change of that indicator in a sticky flag. It holds a remote-wakeup-enable flag. While that flag is set, it turns per-port connect-status changes into a remote-wakeup event. A write can issue a one-cycle global-power command to the ports. Besides the system reset, a synchronous USB-reset request returns every flag to zero.

Top module: `rh_status_reg`

## Requirements
- R1: After the asynchronous active-low system reset, a selected read returns 0 (with the over-current input low) and all three outputs are low.
- R2: While `usbReset` is high at a clock edge, the wakeup-enable flag, the over-current change flag and both pulse outputs are 0 after that edge, and any write presented in the same cycle has no effect. The synchronized over-current level in bit 1 keeps tracking the input.
- R3: Bits 31, 30..18, 16, 14..2 and 0 always read as 0. Writes to 30..18, 14..2, 1 and 0 change nothing that can be observed.
- R4: A write (select and write enable both high) with bit 15 = 1 sets the wakeup-enable flag, which then reads back in bit 15 and drives `wakeEnable`. Writing 0 there, or writing without select, leaves the flag unchanged.
- R5: A write with bit 31 = 1 clears the wakeup-enable flag. When bits 31 and 15 are both 1 in the same write, the flag ends up 0.
- R6: A write with bit 16 = 1 drives `globalPowerPulse` high for exactly the one cycle after the write edge. A write with bit 16 = 0 gives no pulse.
- R7: When the over-current input toggles in either direction, bit 1 shows the new level after two clock edges, and bit 17 is set after the third edge.
- R8: Writing 1 to bit 17 clears the change flag and writing 0 leaves it. If a detected change and a clearing write fall on the same edge, the flag stays set.
- R9: Bit 1 reads the synchronized over-current level and is not affected by writes.
- R10: With wakeup enabled, any high bit of `connChange` at an edge makes `remoteWakeEvent` high in the following cycle. With wakeup disabled, it never goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| usbReset | input | 1 | Synchronous USB-reset request, returns flags to zero |
| regSel | input | 1 | Register select from the address decoder |
| regWe | input | 1 | Write enable |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, 0 when not selected |
| overCurrentIn | input | 1 | Asynchronous over-current indicator |
| connChange | input | NUM_PORTS | Per-port connect-status-change flags |
| wakeEnable | output | 1 | Remote-wakeup-enable level |
| globalPowerPulse | output | 1 | One-cycle set-global-power command |
| remoteWakeEvent | output | 1 | Remote-wakeup event pulse |

## Verification
The bench places a clearing write to bit 17 on the same edge where a detected change sets the flag. If the clear were given priority there, that over-current change would be lost. It writes bits 31 and 15 together, which shows whether the clear wins. A reversed priority would leave wakeup enabled. It checks that the over-current change is caught on both the rising and the falling edge of the input, and that bit 1 appears after exactly two edges. It also presents writes during a USB reset, which a design that ignored that request would accept as set commands.

// File: rtl/rh_status_pkg.sv
package rh_status_pkg;
  localparam int RegW        = 32;
  localparam int BitClrWake  = 31;
  localparam int BitOcChange = 17;
  localparam int BitGlbPower = 16;
  localparam int BitWake     = 15;
  localparam int BitOcLevel  = 1;

  typedef struct packed {
    logic clearAll;
    logic setWake;
    logic clrWake;
    logic clrOcChg;
    logic gpCmd;
  } rhStrobes_t;
endpackage

// File: rtl/rh_status_ctrl.sv
module rh_status_ctrl
  import rh_status_pkg::*;
(
  input  logic            usbReset,
  input  logic            regSel,
  input  logic            regWe,
  input  logic [RegW-1:0] regWdata,
  output rhStrobes_t      strb
);
  logic wrAccess;
  logic unusedWdata;

  // Writes are accepted only when selected and not held in USB reset.
  assign wrAccess    = regSel && regWe && !usbReset;
  assign unusedWdata = ^{regWdata[30:18], regWdata[14:0]};

  always_comb begin
    strb          = '0;
    strb.clearAll = usbReset;
    strb.setWake  = wrAccess && regWdata[BitWake];
    strb.clrWake  = wrAccess && regWdata[BitClrWake];
    strb.clrOcChg = wrAccess && regWdata[BitOcChange];
    strb.gpCmd    = wrAccess && regWdata[BitGlbPower];
  end
endmodule

// File: rtl/rh_status_dp.sv
module rh_status_dp
  import rh_status_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rhStrobes_t           strb,
  input  logic                 regSel,
  input  logic                 overCurrentIn,
  input  logic [NUM_PORTS-1:0] connChange,
  output logic [RegW-1:0]      regRdata,
  output logic                 wakeEnable,
  output logic                 globalPowerPulse,
  output logic                 remoteWakeEvent
);
  logic [SYNC_DEPTH-1:0] ocChain;
  logic ocSync, ocPrev, ocChange, ocChg;
  logic anyConn;
  logic [RegW-1:0] word;

  generate
    if (SYNC_DEPTH < 2) begin : g_bad_depth
      initial $error("SYNC_DEPTH must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocChain <= '0;
      ocPrev  <= 1'b0;
    end else begin
      ocChain <= {ocChain[SYNC_DEPTH-2:0], overCurrentIn};
      ocPrev  <= ocSync;
    end
  end

  assign ocSync   = ocChain[SYNC_DEPTH-1];
  assign ocChange = ocSync ^ ocPrev;
  assign anyConn  = |connChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocChg            <= 1'b0;
      wakeEnable       <= 1'b0;
      globalPowerPulse <= 1'b0;
      remoteWakeEvent  <= 1'b0;
    end else if (strb.clearAll) begin
      ocChg            <= 1'b0;
      wakeEnable       <= 1'b0;
      globalPowerPulse <= 1'b0;
      remoteWakeEvent  <= 1'b0;
    end else begin
      // hardware set outranks software clear
      if (ocChange)           ocChg <= 1'b1;
      else if (strb.clrOcChg) ocChg <= 1'b0;
      // clear outranks set
      if (strb.clrWake)       wakeEnable <= 1'b0;
      else if (strb.setWake)  wakeEnable <= 1'b1;
      globalPowerPulse <= strb.gpCmd;
      remoteWakeEvent  <= wakeEnable && anyConn;
    end
  end

  always_comb begin
    word              = '0;
    word[BitOcChange] = ocChg;
    word[BitWake]     = wakeEnable;
    word[BitOcLevel]  = ocSync;
  end

  assign regRdata = regSel ? word : '0;

  a_r2_usb_reset: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clearAll) |-> (!wakeEnable && !ocChg && !globalPowerPulse && !remoteWakeEvent));
  a_r4_wake_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeEnable) |-> $past(strb.setWake));
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clrWake) |-> !wakeEnable);
  a_r6_pulse_origin: assert property (@(posedge clk) disable iff (!rstN)
    globalPowerPulse |-> $past(strb.gpCmd));
  a_r7_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocChg) |-> $past(ocChange));
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(ocChange && !strb.clearAll) |-> ocChg);
  a_r10_event_gated: assert property (@(posedge clk) disable iff (!rstN)
    remoteWakeEvent |-> $past(wakeEnable));
endmodule

// File: rtl/rh_status_reg.sv
module rh_status_reg
  import rh_status_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 usbReset,
  input  logic                 regSel,
  input  logic                 regWe,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 overCurrentIn,
  input  logic [NUM_PORTS-1:0] connChange,
  output logic                 wakeEnable,
  output logic                 globalPowerPulse,
  output logic                 remoteWakeEvent
);
  rhStrobes_t strb;

  rh_status_ctrl u_ctrl (
    .usbReset (usbReset),
    .regSel   (regSel),
    .regWe    (regWe),
    .regWdata (regWdata),
    .strb     (strb)
  );

  rh_status_dp #(.NUM_PORTS(NUM_PORTS), .SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strb             (strb),
    .regSel           (regSel),
    .overCurrentIn    (overCurrentIn),
    .connChange       (connChange),
    .regRdata         (regRdata),
    .wakeEnable       (wakeEnable),
    .globalPowerPulse (globalPowerPulse),
    .remoteWakeEvent  (remoteWakeEvent)
  );
endmodule

// File: tb/rh_status_reg_test.sv
module rh_status_reg_test;
  localparam int NP = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usbReset = 1'b0;
  logic regSel = 1'b1;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic overCurrentIn = 1'b0;
  logic [NP-1:0] connChange = '0;
  logic [31:0] regRdata;
  logic wakeEnable, globalPowerPulse, remoteWakeEvent;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rh_status_reg #(.NUM_PORTS(NP)) uut (
    .clk(clk), .rstN(rstN), .usbReset(usbReset), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .overCurrentIn(overCurrentIn),
    .connChange(connChange), .wakeEnable(wakeEnable),
    .globalPowerPulse(globalPowerPulse), .remoteWakeEvent(remoteWakeEvent)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, output logic pulseSeen);
    @(negedge clk); regWe = 1'b1; regWdata = d;
    @(negedge clk); pulseSeen = globalPowerPulse; regWe = 1'b0; regWdata = '0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rdata", regRdata, 32'h0);
    chk("R1 outputs", {29'b0, wakeEnable, globalPowerPulse, remoteWakeEvent}, 32'h0);
  endtask

  task automatic t_wake_set();
    logic p;
    doWrite(32'h0, p);            chk("R4 write0", regRdata, 32'h0);
    regSel = 1'b0;
    doWrite(32'h0000_8000, p);    regSel = 1'b1;
    chk("R4 unselected", {31'b0, wakeEnable}, 32'h0);
    doWrite(32'h0000_8000, p);    chk("R4 set rdata", regRdata, 32'h0000_8000);
    chk("R4 level", {31'b0, wakeEnable}, 32'h1);
    doWrite(32'h0, p);            chk("R4 hold", regRdata, 32'h0000_8000);
  endtask

  task automatic t_wake_clear();
    logic p;
    doWrite(32'h8000_0000, p);    chk("R5 clear", regRdata, 32'h0);
    doWrite(32'h0000_8000, p);
    doWrite(32'h8000_8000, p);    chk("R5 clear wins", {31'b0, wakeEnable}, 32'h0);
    chk("R3 bit31 reads 0", regRdata, 32'h0);
  endtask

  task automatic t_reserved();
    logic p;
    doWrite(32'h7FFC_7FFF, p);
    chk("R3 reserved", regRdata, 32'h0);
    chk("R9 bit1 write ignored", {31'b0, regRdata[1]}, 32'h0);
    chk("R3 no pulse", {31'b0, p}, 32'h0);
  endtask

  task automatic t_gpower();
    logic p;
    doWrite(32'h0001_0000, p);    chk("R6 pulse", {31'b0, p}, 32'h1);
    chk("R3 bit16 reads 0", regRdata, 32'h0);
    @(negedge clk);               chk("R6 one cycle", {31'b0, globalPowerPulse}, 32'h0);
    doWrite(32'h0, p);            chk("R6 write0", {31'b0, p}, 32'h0);
  endtask

  task automatic t_overcurrent();
    logic p;
    overCurrentIn = 1'b1;
    @(negedge clk);               chk("R7 edge1", regRdata, 32'h0);
    @(negedge clk);               chk("R9 level after sync", regRdata, 32'h0000_0002);
    @(negedge clk);               chk("R7 rise flagged", regRdata, 32'h0002_0002);
    doWrite(32'h0, p);            chk("R8 write0 keeps", regRdata, 32'h0002_0002);
    doWrite(32'h0002_0000, p);    chk("R8 clear", regRdata, 32'h0000_0002);
    overCurrentIn = 1'b0;
    waitCycles(3);                chk("R7 fall flagged", regRdata, 32'h0002_0000);
    doWrite(32'h0002_0000, p);    chk("R8 clear2", regRdata, 32'h0);
  endtask

  task automatic t_set_wins();
    logic p;
    overCurrentIn = 1'b1;
    @(negedge clk);
    doWrite(32'h0002_0000, p);    chk("R8 set wins", regRdata, 32'h0002_0002);
    overCurrentIn = 1'b0;
    waitCycles(3);
    doWrite(32'h0002_0000, p);    chk("R8 cleanup", regRdata, 32'h0);
  endtask

  task automatic t_wake_event();
    logic p;
    @(negedge clk); connChange = 4'b0100;
    @(negedge clk);               chk("R10 disabled", {31'b0, remoteWakeEvent}, 32'h0);
    connChange = '0;
    doWrite(32'h0000_8000, p);
    @(negedge clk); connChange = 4'b1000;
    @(negedge clk);               chk("R10 event", {31'b0, remoteWakeEvent}, 32'h1);
    connChange = '0;
    @(negedge clk);               chk("R10 event ends", {31'b0, remoteWakeEvent}, 32'h0);
  endtask

  task automatic t_usb_reset();
    overCurrentIn = 1'b1;
    waitCycles(3);                chk("R2 pre", regRdata, 32'h0002_8002);
    @(negedge clk); usbReset = 1'b1; regWe = 1'b1; regWdata = 32'h0001_8000;
    @(negedge clk);
    chk("R2 cleared", regRdata, 32'h0000_0002);
    chk("R2 outputs", {29'b0, wakeEnable, globalPowerPulse, remoteWakeEvent}, 32'h0);
    usbReset = 1'b0; regWe = 1'b0; regWdata = '0;
    @(negedge clk);               chk("R2 after", regRdata, 32'h0000_0002);
    chk("R2 no pulse", {31'b0, globalPowerPulse}, 32'h0);
  endtask

  initial begin
    waitCycles(3);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_wake_set();
    t_wake_clear();
    t_reserved();
    t_gpower();
    t_overcurrent();
    t_set_wins();
    t_wake_event();
    t_usb_reset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule